// File: doc/BRIEF.md
# Retransmit FIFO Buffer with Half-Full Flag

This block is a single-clock first-in/first-out buffer. It stores 9-bit words by default, so one bit can carry parity or a control marker. There are no address inputs. A write strobe loads a word and a read strobe unloads one. Both strobes are active low and are sampled on the clock. Circular write and read pointers index an inferred RAM, and the two strobes may act in the same cycle. The buffer reports empty, full and half-full. It refuses writes when full and reads when empty.

A retransmit pulse sends the read pointer back to the first location. The words written since reset can then be read again from the beginning. The occupancy is recomputed from the write pointer, capped at the depth once that pointer has wrapped, and the flags follow the new occupancy. The depth must be a power of two, with values from 512 to 16384 intended. The bench uses a small depth.

Top module: `rtx_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, the occupancy is set to zero and both pointers return to location 0. One cycle later `empty`=1, `full`=0, `half_full`=0 and `dout`=0.
- R2: A write happens on the clock edge where `wr_n` is sampled high after being sampled low on the previous edge. At that edge `din` is stored at the write pointer, which then advances. No address is supplied.
- R3: A read happens on the edge where `rd_n` is sampled low after being sampled high. At that edge `dout` is loaded with the oldest stored word, so words leave in the order they were written.
- R4: A write event and a read event on the same edge both take effect, provided the buffer is neither full nor empty. The occupancy and the flags are then unchanged.
- R5: `empty` is 1 exactly when the occupancy is 0. A read event while empty is ignored: `dout` holds its value and the read pointer does not move.
- R6: `full` is 1 exactly when the occupancy equals DEPTH. A write event while full is ignored: the word is not stored and the occupancy stays at DEPTH.
- R7: `half_full` is 1 exactly when the occupancy is at least DEPTH/2+1.
- R8: On the edge where `rt_n` is sampled low after being sampled high, the read pointer returns to location 0. Later reads replay data starting from the first word written after reset. The occupancy becomes the write pointer, or DEPTH if the write pointer has wrapped, and the flags follow it. The write pointer is not changed, and a read event on the same edge is ignored.
- R9: A strobe held at one level for many cycles produces exactly one event.
- R10: The data path is WIDTH bits wide (default 9), and every bit, including the top one, is stored and returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Active-low write strobe; the word is stored on its release |
| rd_n | input | 1 | Active-low read strobe; a word is presented on its assertion |
| rt_n | input | 1 | Active-low retransmit pulse |
| din | input | WIDTH | Write data |
| dout | output | WIDTH | Registered read data |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy equals DEPTH |
| half_full | output | 1 | Occupancy is above half the depth |

## Verification
The bound checker compares each registered flag with the occupancy counter on every cycle. It also checks that a read while empty leaves the output word untouched, that a write while full keeps the buffer full, and that the flags are in their cleared state after reset. First-in/first-out ordering, replay of the stored sequence after a retransmit, a single event for a held strobe, and the simultaneous read and write case depend on data values across many cycles. Only the directed scenarios, with their reference queue, can show these.

// File: rtl/rtx_fifo_pkg.sv
package rtx_fifo_pkg;
  typedef struct packed {
    logic wr;
    logic rd;
    logic rt;
  } strobe_evt_t;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter bit RISE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= strobe_n;
  end

  generate
    if (RISE) begin : g_rise
      assign pulse = !prev_q && strobe_n && !rst;
    end else begin : g_fall
      assign pulse = prev_q && !strobe_n && !rst;
    end
  endgenerate
endmodule

// File: rtl/fifo_ptr_ctl.sv
module fifo_ptr_ctl
  import rtx_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH),
  parameter int OW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  strobe_evt_t   evt,
  output logic          wr_en,
  output logic          rd_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [OW-1:0] occ_q,
  output logic [OW-1:0] occ_next
);
  localparam logic [OW-1:0] OCC_FULL = OW'(DEPTH);
  localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);

  logic [AW-1:0] wptr_q, rptr_q, wptr_next, rptr_next;
  logic          wrapped_q, wrapped_next;

  always_comb begin
    wr_en        = evt.wr && (occ_q != OCC_FULL);
    rd_en        = evt.rd && (occ_q != '0) && !evt.rt;
    wptr_next    = wr_en ? wptr_q + 1'b1 : wptr_q;
    wrapped_next = wrapped_q || (wr_en && (wptr_q == LAST));
    if (evt.rt) begin
      rptr_next = '0;
      occ_next  = wrapped_next ? OCC_FULL : {1'b0, wptr_next};
    end else begin
      rptr_next = rd_en ? rptr_q + 1'b1 : rptr_q;
      occ_next  = occ_q + {{(OW-1){1'b0}}, wr_en} - {{(OW-1){1'b0}}, rd_en};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q    <= '0;
      rptr_q    <= '0;
      wrapped_q <= 1'b0;
      occ_q     <= '0;
    end else begin
      wptr_q    <= wptr_next;
      rptr_q    <= rptr_next;
      wrapped_q <= wrapped_next;
      occ_q     <= occ_next;
    end
  end

  assign wr_addr = wptr_q;
  assign rd_addr = rptr_q;
endmodule

// File: rtl/fifo_flags.sv
module fifo_flags #(
  parameter int DEPTH = 512,
  parameter int OW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [OW-1:0] occ_next,
  output logic          empty,
  output logic          full,
  output logic          half_full
);
  localparam logic [OW-1:0] OCC_FULL = OW'(DEPTH);
  localparam logic [OW-1:0] OCC_HALF = OW'(DEPTH / 2 + 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      empty     <= 1'b1;
      full      <= 1'b0;
      half_full <= 1'b0;
    end else begin
      empty     <= (occ_next == '0);
      full      <= (occ_next == OCC_FULL);
      half_full <= (occ_next >= OCC_HALF);
    end
  end
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/rtx_fifo.sv
module rtx_fifo
  import rtx_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             rt_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full,
  output logic             half_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int OW = AW + 1;

  strobe_evt_t   evt;
  logic          wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [OW-1:0] occ_q, occ_next;

  strobe_edge #(.RISE(1'b1)) u_wr_edge (.clk(clk), .rst(rst), .strobe_n(wr_n), .pulse(evt.wr));
  strobe_edge #(.RISE(1'b0)) u_rd_edge (.clk(clk), .rst(rst), .strobe_n(rd_n), .pulse(evt.rd));
  strobe_edge #(.RISE(1'b0)) u_rt_edge (.clk(clk), .rst(rst), .strobe_n(rt_n), .pulse(evt.rt));

  fifo_ptr_ctl #(.DEPTH(DEPTH), .AW(AW), .OW(OW)) u_ptr (
    .clk(clk), .rst(rst), .evt(evt),
    .wr_en(wr_en), .rd_en(rd_en),
    .wr_addr(wr_addr), .rd_addr(rd_addr),
    .occ_q(occ_q), .occ_next(occ_next)
  );

  fifo_flags #(.DEPTH(DEPTH), .OW(OW)) u_flags (
    .clk(clk), .rst(rst), .occ_next(occ_next),
    .empty(empty), .full(full), .half_full(half_full)
  );

  fifo_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_ram (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(din),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(dout)
  );
endmodule

// File: rtl/rtx_fifo_chk.sv
module rtx_fifo_chk #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9,
  parameter int OW    = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_n,
  input logic             rd_n,
  input logic             rt_n,
  input logic [WIDTH-1:0] dout,
  input logic             empty,
  input logic             full,
  input logic             half_full,
  input logic [OW-1:0]    occ
);
  localparam logic [OW-1:0] OCC_FULL = OW'(DEPTH);
  localparam logic [OW-1:0] OCC_HALF = OW'(DEPTH / 2 + 1);

  logic wr_p, rd_p, rt_p;
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_p <= 1'b1;
      rd_p <= 1'b1;
      rt_p <= 1'b1;
    end else begin
      wr_p <= wr_n;
      rd_p <= rd_n;
      rt_p <= rt_n;
    end
  end

  logic wr_ev, rd_ev, rt_ev;
  assign wr_ev = !wr_p && wr_n;
  assign rd_ev = rd_p && !rd_n;
  assign rt_ev = rt_p && !rt_n;

  AST_RESET_FLAGS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (empty && !full && !half_full && dout == '0)); // R1
  AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (rst)
    empty == (occ == '0)); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_ev) |=> $stable(dout)); // R5
  AST_FULL_MATCH: assert property (@(posedge clk) disable iff (rst)
    full == (occ == OCC_FULL)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full && wr_ev && !rd_ev && !rt_ev) |=> full); // R6
  AST_HALF_MATCH: assert property (@(posedge clk) disable iff (rst)
    half_full == (occ >= OCC_HALF)); // R7
  AST_FULL_IMPLIES_HALF: assert property (@(posedge clk) disable iff (rst)
    full |-> (half_full && !empty)); // R7
endmodule

bind rtx_fifo rtx_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
  .dout(dout), .empty(empty), .full(full), .half_full(half_full),
  .occ(occ_q)
);

// File: tb/rtx_fifo_tb_top.sv
module rtx_fifo_tb_top;
  localparam int DEPTH = 16;
  localparam int WIDTH = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] dout;
  logic empty, full, half_full;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [WIDTH-1:0] hist[$];
  int rd_pos;
  int occ;
  logic [WIDTH-1:0] last_dout;

  always #2.5 clk = ~clk;

  rtx_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst(rst), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
    .din(din), .dout(dout), .empty(empty), .full(full), .half_full(half_full)
  );

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_flags(string req);
    check(req, "empty", empty, occ == 0);
    check(req, "full", full, occ == DEPTH);
    check(req, "half_full", half_full, occ >= DEPTH / 2 + 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    hist.delete();
    rd_pos = 0; occ = 0; last_dout = '0;
  endtask

  task automatic write_word(logic [WIDTH-1:0] d);
    @(negedge clk); din = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk);
    if (occ < DEPTH) begin hist.push_back(d); occ++; end
  endtask

  task automatic read_word(string req);
    @(negedge clk); rd_n = 1'b0;
    @(negedge clk);
    if (occ > 0) begin last_dout = hist[rd_pos]; rd_pos++; occ--; end
    check(req, "dout", dout, last_dout);
    rd_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "empty", empty, 1);
    check("R1", "full", full, 0);
    check("R1", "half_full", half_full, 0);
    check("R1", "dout", dout, 0);
  endtask

  task automatic t_order();
    do_reset();
    write_word(9'h1A5); write_word(9'h05A); write_word(9'h100);
    check_flags("R2");
    read_word("R3"); read_word("R10"); read_word("R3");
    check_flags("R5");
  endtask

  task automatic t_half();
    do_reset();
    for (int i = 0; i < DEPTH / 2; i++) write_word(WIDTH'(i + 3));
    check("R7", "half_full at DEPTH/2", half_full, 0);
    write_word(9'h1FF);
    check("R7", "half_full at DEPTH/2+1", half_full, 1);
    read_word("R7");
    check("R7", "half_full after read", half_full, 0);
  endtask

  task automatic t_full_empty();
    do_reset();
    for (int i = 0; i < DEPTH; i++) write_word(WIDTH'(9'h0F0 + i));
    check("R6", "full", full, 1);
    write_word(9'h0EE);
    check("R6", "occupancy after write while full", full, 1);
    for (int i = 0; i < DEPTH; i++) read_word("R6");
    check("R5", "empty after drain", empty, 1);
    read_word("R5");
    check("R5", "empty after read while empty", empty, 1);
    write_word(9'h033);
    read_word("R5");
  endtask

  task automatic t_simul();
    do_reset();
    write_word(9'h111); write_word(9'h022);
    @(negedge clk); din = 9'h133; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    hist.push_back(9'h133);
    last_dout = hist[rd_pos]; rd_pos++;
    check("R4", "dout on joint event", dout, last_dout);
    check_flags("R4");
    rd_n = 1'b1;
    read_word("R4"); read_word("R4");
    check("R4", "empty at end", empty, 1);
  endtask

  task automatic t_hold();
    do_reset();
    write_word(9'h0AB); write_word(9'h0CD);
    @(negedge clk); rd_n = 1'b0;
    repeat (5) @(negedge clk);
    last_dout = hist[rd_pos]; rd_pos++; occ--;
    check("R9", "dout with held read strobe", dout, last_dout);
    check_flags("R9");
    rd_n = 1'b1;
    read_word("R9");
  endtask

  task automatic t_retransmit();
    do_reset();
    write_word(9'h101); write_word(9'h102); write_word(9'h103);
    read_word("R8"); read_word("R8");
    @(negedge clk); rt_n = 1'b0;
    @(negedge clk); rt_n = 1'b1;
    rd_pos = 0; occ = hist.size();
    check_flags("R8");
    read_word("R8"); read_word("R8"); read_word("R8");
    check("R8", "empty after replay", empty, 1);
    write_word(9'h104);
    read_word("R8");
    do_reset();
    for (int i = 0; i < DEPTH; i++) write_word(WIDTH'(9'h040 + i));
    for (int i = 0; i < 4; i++) read_word("R8");
    @(negedge clk); rt_n = 1'b0;
    @(negedge clk); rt_n = 1'b1;
    rd_pos = 0; occ = DEPTH;
    check("R8", "full after wrapped retransmit", full, 1);
    read_word("R8");
  endtask

  initial begin
    t_reset();
    t_order();
    t_half();
    t_full_empty();
    t_simul();
    t_hold();
    t_retransmit();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule